// File: doc/BRIEF.md
# Multi-Cycle 8-bit CPU Sequencer with Load Wait State

This block is the control core and bus master of a small 8-bit multi-cycle processor. Each instruction is fetched from a 16-bit instruction port, decoded, executed and written back. The block reads two operands from a small register file, computes an ALU result or drives the data bus, and updates the program counter in writeback. The data bus serves a memory whose read data appears one clock after the request, so loads insert a single wait state. During that wait state the address and read strobe stay unchanged, and the returned byte is captured at the end of the wait state.

Branches resolve in writeback from a registered flag byte. Bit 3 of that byte is the zero flag, and only arithmetic and logic operations update the flags. A halt instruction parks the sequencer until the next reset.

Top module: `cpu_seq`

## Requirements
- R1: After active-low reset is released, the core is in the fetch step with `imem_rd`=1 and `imem_addr`=0. The data bus is idle (`bus_addr`=0, `bus_wdata`=0, `bus_we`=0, `bus_re`=0) and `halted`=0.
- R2: Instruction cycle counts are fixed. A load (opcode 6) takes 5 clock cycles from one fetch to the next. Every other non-halt instruction takes 4.
- R3: A store (opcode 7) drives `bus_addr` = register[ra] and `bus_wdata` = register[rb], with `bus_we` high for exactly one cycle.
- R4: A load raises `bus_re` for exactly two consecutive cycles with an unchanged `bus_addr` = register[ra]. Register rd receives the `bus_rdata` value present in the second of those cycles.
- R5: `bus_we` and `bus_re` are never high together. While both are low, `bus_addr` and `bus_wdata` are zero. Non-memory instructions raise neither strobe.
- R6: A branch loads the program counter with imm[7:0] when it is taken, and otherwise the counter increments by 1. JMP (opcode 8) is always taken. BZ (opcode 9) is taken when flag bit 3 is set. BNZ (opcode 10) is taken when flag bit 3 is clear.
- R7: Only ADD (1), SUB (2), AND (3) and XOR (4) update the flags, with bit 3 set when the result is zero. LDI (5), LD, ST and branches leave the flags unchanged.
- R8: HLT (opcode 15) sets `halted`. From then until reset there is no fetch and no bus strobe, and `imem_addr` holds.
- R9: The instruction format is [15:12] opcode, [11:10] rd, [9:8] ra, [7:6] rb and [7:0] imm. ADD, SUB, AND and XOR write ra op rb into rd. LDI writes imm into rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 8 | Instruction address (program counter) |
| imem_rd | output | 1 | High in the fetch cycle |
| imem_data | input | 16 | Instruction word, combinational from `imem_addr` |
| bus_addr | output | 8 | Data bus address |
| bus_wdata | output | 8 | Data bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid one cycle after the request |
| halted | output | 1 | High while parked after HLT |

## Verification
On every cycle, the assertions check the bus shape: mutually exclusive strobes, a zeroed idle bus, a one-cycle write pulse, and a two-cycle read with a stable address. They also check the load-only wait state, the counter increment on untaken branches, and that halt is absorbing and silent. Only the directed scenarios can show that the right byte lands in the register. They do this by running a store-then-load round trip through a one-clock-latency memory and writing the loaded value back out. The scenarios also cover exact per-class cycle counts measured between fetches, and branch decisions that depend on which instructions left the flags untouched.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int INSTR_W   = 16;
    localparam int REG_CNT   = 4;
    localparam int RIDX_W    = $clog2(REG_CNT);
    localparam int FLAG_W    = 4;
    localparam int ZERO_BIT  = 3;

    typedef enum logic [2:0] {
        S_FETCH   = 3'd0,
        S_DECODE  = 3'd1,
        S_EXECUTE = 3'd2,
        S_MEMWAIT = 3'd3,
        S_WB      = 3'd4,
        S_HALT    = 3'd5
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_XOR = 4'd4,
        OP_LDI = 4'd5,
        OP_LD  = 4'd6,
        OP_ST  = 4'd7,
        OP_JMP = 4'd8,
        OP_BZ  = 4'd9,
        OP_BNZ = 4'd10,
        OP_HLT = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e             alu_fn;
        logic                is_alu;
        logic                is_ldi;
        logic                is_ld;
        logic                is_st;
        logic                is_jmp;
        logic                is_bz;
        logic                is_bnz;
        logic                is_hlt;
        logic                wr_rd;
        logic [RIDX_W-1:0]   rd;
        logic [RIDX_W-1:0]   ra;
        logic [RIDX_W-1:0]   rb;
        logic [DATA_W-1:0]   imm;
    } ctrl_t;

    typedef struct packed {
        seq_state_e          st;
        logic [ADDR_W-1:0]   pc;
        logic [INSTR_W-1:0]  ir;
        logic [DATA_W-1:0]   op_a;
        logic [DATA_W-1:0]   op_b;
        logic [DATA_W-1:0]   result;
        logic [FLAG_W-1:0]   flags;
        logic [FLAG_W-1:0]   alu_flags;
    } seq_regs_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import cpu_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctl
);
    localparam int OPC_LSB = INSTR_W - 4;
    localparam int RD_LSB  = OPC_LSB - RIDX_W;
    localparam int RA_LSB  = RD_LSB - RIDX_W;
    localparam int RB_LSB  = RA_LSB - RIDX_W;

    logic [3:0] opc;

    always_comb begin
        opc        = instr[INSTR_W-1:OPC_LSB];
        ctl        = '0;
        ctl.rd     = instr[RD_LSB +: RIDX_W];
        ctl.ra     = instr[RA_LSB +: RIDX_W];
        ctl.rb     = instr[RB_LSB +: RIDX_W];
        ctl.imm    = instr[DATA_W-1:0];
        ctl.alu_fn = ALU_ADD;
        case (opc)
            OP_ADD: begin ctl.is_alu = 1'b1; ctl.wr_rd = 1'b1; ctl.alu_fn = ALU_ADD; end
            OP_SUB: begin ctl.is_alu = 1'b1; ctl.wr_rd = 1'b1; ctl.alu_fn = ALU_SUB; end
            OP_AND: begin ctl.is_alu = 1'b1; ctl.wr_rd = 1'b1; ctl.alu_fn = ALU_AND; end
            OP_XOR: begin ctl.is_alu = 1'b1; ctl.wr_rd = 1'b1; ctl.alu_fn = ALU_XOR; end
            OP_LDI: begin ctl.is_ldi = 1'b1; ctl.wr_rd = 1'b1; end
            OP_LD:  begin ctl.is_ld  = 1'b1; ctl.wr_rd = 1'b1; end
            OP_ST:  ctl.is_st  = 1'b1;
            OP_JMP: ctl.is_jmp = 1'b1;
            OP_BZ:  ctl.is_bz  = 1'b1;
            OP_BNZ: ctl.is_bnz = 1'b1;
            OP_HLT: ctl.is_hlt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import cpu_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_fn_e           fn,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output logic [DW-1:0]     y,
    output logic [FLAG_W-1:0] flags
);
    logic carry;

    always_comb begin
        carry = 1'b0;
        case (fn)
            ALU_ADD: {carry, y} = {1'b0, a} + {1'b0, b};
            ALU_SUB: {carry, y} = {1'b0, a} - {1'b0, b};
            ALU_AND: y = a & b;
            default: y = a ^ b;
        endcase
        flags = {(y == '0), y[DW-1], carry, ^y};
    end

endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter int DW    = 8,
    parameter int NREGS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(NREGS)-1:0] rd_idx_a,
    output logic [DW-1:0]            rd_data_a,
    input  logic [$clog2(NREGS)-1:0] rd_idx_b,
    output logic [DW-1:0]            rd_data_b
);
    localparam int IDX_W = $clog2(NREGS);

    logic [DW-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    assign rd_data_a = regs_q[rd_idx_a];
    assign rd_data_b = regs_q[rd_idx_b];

endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
    import cpu_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   imem_addr,
    output logic                imem_rd,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_we,
    output logic                bus_re,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic                halted
);
    seq_regs_t          q, d;
    ctrl_t              ctl;
    logic [DATA_W-1:0]  rf_a, rf_b, alu_y;
    logic [FLAG_W-1:0]  alu_f;
    logic               rf_we;
    logic               take_br;

    seq_decode u_dec (
        .instr (q.ir),
        .ctl   (ctl)
    );

    seq_regfile #(.DW(DATA_W), .NREGS(REG_CNT)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (rf_we),
        .wr_idx    (ctl.rd),
        .wr_data   (q.result),
        .rd_idx_a  (ctl.ra),
        .rd_data_a (rf_a),
        .rd_idx_b  (ctl.rb),
        .rd_data_b (rf_b)
    );

    seq_alu #(.DW(DATA_W)) u_alu (
        .fn    (ctl.alu_fn),
        .a     (q.op_a),
        .b     (q.op_b),
        .y     (alu_y),
        .flags (alu_f)
    );

    // Branch decision from the registered flag byte.
    assign take_br = ctl.is_jmp
                   | (ctl.is_bz  &  q.flags[ZERO_BIT])
                   | (ctl.is_bnz & ~q.flags[ZERO_BIT]);

    always_comb begin
        d         = q;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        rf_we     = 1'b0;
        case (q.st)
            S_FETCH: begin
                d.ir = imem_data;
                d.st = S_DECODE;
            end
            S_DECODE: begin
                d.op_a = rf_a;
                d.op_b = rf_b;
                d.st   = ctl.is_hlt ? S_HALT : S_EXECUTE;
            end
            S_EXECUTE: begin
                if (ctl.is_st) begin
                    bus_addr  = q.op_a;
                    bus_wdata = q.op_b;
                    bus_we    = 1'b1;
                end
                if (ctl.is_ld) begin
                    bus_addr = q.op_a;
                    bus_re   = 1'b1;
                    d.st     = S_MEMWAIT;
                end else begin
                    d.result    = ctl.is_ldi ? ctl.imm : alu_y;
                    d.alu_flags = alu_f;
                    d.st        = S_WB;
                end
            end
            S_MEMWAIT: begin
                // Request held so the registered-read memory returns now.
                bus_addr = q.op_a;
                bus_re   = 1'b1;
                d.result = bus_rdata;
                d.st     = S_WB;
            end
            S_WB: begin
                rf_we = ctl.wr_rd;
                if (ctl.is_alu) begin
                    d.flags = q.alu_flags;
                end
                d.pc = take_br ? ctl.imm : q.pc + ADDR_W'(1);
                d.st = S_FETCH;
            end
            S_HALT: d.st = S_HALT;
            default: d.st = S_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign imem_addr = q.pc;
    assign imem_rd   = (q.st == S_FETCH);
    assign halted    = (q.st == S_HALT);

    // ---------------- assertions ----------------
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we || bus_re) |-> (bus_addr == '0 && bus_wdata == '0));

    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    p_re_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && q.st == S_EXECUTE) |=> (bus_re && $stable(bus_addr)));

    p_re_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && q.st == S_MEMWAIT) |=> !bus_re);

    p_ld_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EXECUTE && ctl.is_ld) |=> (q.st == S_MEMWAIT));

    p_other_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_EXECUTE && !ctl.is_ld) |=> (q.st == S_WB));

    p_pc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_WB && !take_br) |=> (imem_addr == ADDR_W'($past(imem_addr) + 1)));

    p_halt_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(imem_addr)));

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!imem_rd && !bus_we && !bus_re));

endmodule

// File: tb/sim_cpu_seq.sv
`timescale 1ns/1ps
module sim_cpu_seq;

    localparam logic [3:0] K_ADD = 4'd1, K_SUB = 4'd2, K_AND = 4'd3, K_XOR = 4'd4,
                           K_LDI = 4'd5, K_LD = 4'd6, K_ST = 4'd7, K_JMP = 4'd8,
                           K_BZ = 4'd9, K_BNZ = 4'd10, K_HLT = 4'd15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic        imem_rd;
    logic [15:0] imem_data;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic        bus_we, bus_re, halted;

    logic [15:0] rom [256];
    logic [7:0]  dmem [256];
    logic        mem_clr = 1'b1;
    logic        mon_clr = 1'b1;

    int checks = 0, errors = 0;
    int cyc, nf, we_cnt, we_bad, re_cnt, re_bad, re_run, idle_bad, halt_act;
    int fetch_cyc [16];
    logic [7:0] re_addr;
    logic prev_we;

    always #4 clk = ~clk;

    cpu_seq u0 (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rd(imem_rd),
        .imem_data(imem_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .halted(halted)
    );

    assign imem_data = rom[imem_addr];

    // One-clock-latency data memory.
    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 8'h00;
            bus_rdata <= 8'h00;
        end else begin
            if (bus_we) dmem[bus_addr] <= bus_wdata;
            if (bus_re) bus_rdata <= dmem[bus_addr];
        end
    end

    // Bus monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (mon_clr) begin
            cyc = 0; nf = 0; we_cnt = 0; we_bad = 0; re_cnt = 0; re_bad = 0;
            re_run = 0; idle_bad = 0; halt_act = 0; prev_we = 1'b0; re_addr = 8'h00;
        end else begin
            cyc++;
            if (imem_rd && nf < 16) begin fetch_cyc[nf] = cyc; nf++; end
            if (bus_we) begin we_cnt++; if (prev_we) we_bad++; end
            prev_we = bus_we;
            if (bus_re) begin
                if (re_run == 0) re_addr = bus_addr;
                else if (bus_addr != re_addr) re_bad++;
                re_run++;
            end else if (re_run != 0) begin
                if (re_run != 2) re_bad++;
                re_cnt++;
                re_run = 0;
            end
            if ((bus_we && bus_re) || (!bus_we && !bus_re && (bus_addr != 0 || bus_wdata != 0)))
                idle_bad++;
            if (halted && (bus_we || bus_re || imem_rd)) halt_act++;
        end
    end

    function automatic logic [15:0] enc_r(input logic [3:0] op, input logic [1:0] rd,
                                          input logic [1:0] ra, input logic [1:0] rb);
        return {op, rd, ra, rb, 6'd0};
    endfunction

    function automatic logic [15:0] enc_i(input logic [3:0] op, input logic [1:0] rd,
                                          input logic [7:0] imm);
        return {op, rd, 2'b00, imm};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = {K_HLT, 12'h000};
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; mem_clr = 1'b1; mon_clr = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1; mem_clr = 1'b0; mon_clr = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic run_prog(input int max);
        bit done = 0;
        for (int i = 0; i < max && !done; i++) begin
            if (halted) done = 1;
            else begin @(negedge clk); #1; end
        end
        chk(halted, "R8 program halts", halted, 1);
    endtask

    task automatic t_reset();
        clear_rom();
        do_reset();
        chk(imem_addr == 0 && imem_rd, "R1 fetch at pc 0", imem_addr, 0);
        chk(!bus_we && !bus_re && bus_addr == 0 && bus_wdata == 0, "R1 idle bus",
            {bus_we, bus_re, bus_addr}, 0);
        chk(!halted, "R1 not halted", halted, 0);
    endtask

    task automatic t_alu();
        clear_rom();
        rom[0]  = enc_i(K_LDI, 0, 8'h0C);
        rom[1]  = enc_i(K_LDI, 1, 8'h0A);
        rom[2]  = enc_r(K_ADD, 2, 0, 1);
        rom[3]  = enc_i(K_LDI, 3, 8'h10);
        rom[4]  = enc_r(K_ST, 0, 3, 2);
        rom[5]  = enc_r(K_SUB, 2, 0, 1);
        rom[6]  = enc_i(K_LDI, 3, 8'h11);
        rom[7]  = enc_r(K_ST, 0, 3, 2);
        rom[8]  = enc_r(K_AND, 2, 0, 1);
        rom[9]  = enc_i(K_LDI, 3, 8'h12);
        rom[10] = enc_r(K_ST, 0, 3, 2);
        rom[11] = enc_r(K_XOR, 2, 0, 1);
        rom[12] = enc_i(K_LDI, 3, 8'h13);
        rom[13] = enc_r(K_ST, 0, 3, 2);
        do_reset();
        run_prog(400);
        chk(dmem[8'h10] == 8'h16, "R9 ADD", dmem[8'h10], 8'h16);
        chk(dmem[8'h11] == 8'h02, "R9 SUB", dmem[8'h11], 8'h02);
        chk(dmem[8'h12] == 8'h08, "R9 AND", dmem[8'h12], 8'h08);
        chk(dmem[8'h13] == 8'h06, "R9 XOR", dmem[8'h13], 8'h06);
        chk(we_cnt == 4, "R3 one write cycle per store", we_cnt, 4);
        chk(re_cnt == 0, "R5 no read from ALU code", re_cnt, 0);
        chk(idle_bad == 0, "R5 idle bus zero", idle_bad, 0);
    endtask

    task automatic t_store_load();
        clear_rom();
        rom[0] = enc_i(K_LDI, 0, 8'h20);
        rom[1] = enc_i(K_LDI, 1, 8'hA5);
        rom[2] = enc_r(K_ST, 0, 0, 1);
        rom[3] = enc_r(K_LD, 2, 0, 0);
        rom[4] = enc_i(K_LDI, 3, 8'h21);
        rom[5] = enc_r(K_ST, 0, 3, 2);
        rom[6] = enc_i(K_LDI, 1, 8'h5A);
        rom[7] = enc_r(K_ST, 0, 0, 1);
        rom[8] = enc_r(K_LD, 2, 0, 0);
        rom[9] = enc_i(K_LDI, 3, 8'h22);
        rom[10] = enc_r(K_ST, 0, 3, 2);
        do_reset();
        run_prog(400);
        chk(dmem[8'h21] == 8'hA5, "R4 load returns stored byte", dmem[8'h21], 8'hA5);
        chk(dmem[8'h22] == 8'h5A, "R4 load sees overwrite", dmem[8'h22], 8'h5A);
        chk(dmem[8'h20] == 8'h5A, "R3 store address/data", dmem[8'h20], 8'h5A);
        chk(we_cnt == 4 && we_bad == 0, "R3 single-cycle strobe", we_cnt, 4);
        chk(re_cnt == 2 && re_bad == 0, "R4 two-cycle held read", re_bad, 0);
        chk(idle_bad == 0, "R5 exclusive strobes", idle_bad, 0);
    endtask

    task automatic t_cycles();
        int exp_gap [5] = '{4, 5, 4, 4, 4};
        clear_rom();
        rom[0] = enc_i(K_LDI, 0, 8'h40);
        rom[1] = enc_r(K_LD, 1, 0, 0);
        rom[2] = enc_r(K_ST, 0, 0, 1);
        rom[3] = enc_r(K_ADD, 2, 0, 0);
        rom[4] = enc_i(K_JMP, 0, 8'h06);
        rom[5] = enc_r(K_ST, 0, 0, 0);
        do_reset();
        run_prog(200);
        chk(nf == 6, "R2 fetch count", nf, 6);
        for (int i = 1; i < 6; i++)
            chk(fetch_cyc[i] - fetch_cyc[i-1] == exp_gap[i-1], "R2 cycles per instruction",
                fetch_cyc[i] - fetch_cyc[i-1], exp_gap[i-1]);
        chk(we_cnt == 1, "R6 JMP skips store", we_cnt, 1);
    endtask

    task automatic t_branch();
        clear_rom();
        rom[0]  = enc_i(K_LDI, 0, 8'h03);
        rom[1]  = enc_i(K_LDI, 1, 8'h03);
        rom[2]  = enc_r(K_SUB, 2, 0, 1);
        rom[3]  = enc_i(K_LDI, 3, 8'h30);
        rom[4]  = enc_i(K_BZ, 0, 8'd7);
        rom[5]  = enc_i(K_LDI, 2, 8'hBB);
        rom[7]  = enc_i(K_LDI, 1, 8'h11);
        rom[8]  = enc_r(K_ST, 0, 3, 1);
        rom[9]  = enc_i(K_BNZ, 0, 8'd6);
        rom[10] = enc_i(K_LDI, 1, 8'h22);
        rom[11] = enc_i(K_LDI, 3, 8'h31);
        rom[12] = enc_r(K_ST, 0, 3, 1);
        rom[13] = enc_r(K_ADD, 2, 0, 1);
        rom[14] = enc_i(K_BNZ, 0, 8'd16);
        rom[16] = enc_i(K_LDI, 1, 8'h33);
        rom[17] = enc_i(K_LDI, 3, 8'h32);
        rom[18] = enc_r(K_ST, 0, 3, 1);
        rom[19] = enc_i(K_BZ, 0, 8'd15);
        rom[20] = enc_i(K_JMP, 0, 8'd22);
        rom[22] = enc_i(K_LDI, 1, 8'h44);
        rom[23] = enc_i(K_LDI, 3, 8'h33);
        rom[24] = enc_r(K_ST, 0, 3, 1);
        do_reset();
        run_prog(600);
        chk(dmem[8'h30] == 8'h11, "R6 BZ taken, R7 LDI keeps zero flag", dmem[8'h30], 8'h11);
        chk(dmem[8'h31] == 8'h22, "R6 BNZ not taken on zero", dmem[8'h31], 8'h22);
        chk(dmem[8'h32] == 8'h33, "R6 BNZ taken after ADD, R7", dmem[8'h32], 8'h33);
        chk(dmem[8'h33] == 8'h44, "R6 BZ not taken then JMP", dmem[8'h33], 8'h44);
        chk(imem_addr == 8'd25, "R8 halted at last address", imem_addr, 25);
    endtask

    task automatic t_halt();
        logic [7:0] pc_at;
        int nf_at;
        clear_rom();
        rom[0] = enc_i(K_LDI, 0, 8'h50);
        rom[1] = {K_HLT, 12'h000};
        rom[2] = enc_r(K_ST, 0, 0, 0);
        do_reset();
        run_prog(100);
        pc_at = imem_addr;
        nf_at = nf;
        repeat (20) @(negedge clk);
        #1;
        chk(halted, "R8 halt absorbing", halted, 1);
        chk(imem_addr == pc_at && nf == nf_at, "R8 no fetch while halted", imem_addr, pc_at);
        chk(halt_act == 0 && we_cnt == 0, "R8 bus quiet", halt_act, 0);
        chk(dmem[8'h50] == 8'h00, "R8 store after HLT not run", dmem[8'h50], 0);
        do_reset();
        chk(!halted && imem_addr == 0 && imem_rd, "R1 reset leaves halt", imem_addr, 0);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_store_load();
        t_cycles();
        t_branch();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule